// File: doc/BRIEF.md
# Continuous ADC Scan Sequencer

This block steps an external successive-approximation converter through a small group of analog channels and keeps doing so for as long as its run bit stays set. Software writes one control byte. That byte holds the run bit, the interrupt enable, a group number and a channel count. The block then runs each channel in turn through a sampling phase and a conversion phase. It stores every 10-bit result, left-justified, in a 16-bit register for that channel. After the last channel of the group it sets a sticky end-of-scan flag and starts the group again from its first channel.

Only the first conversion after a start waits for a start delay. That delay ends at the next boundary of a free-running internal clock divider. Later conversions in the scan begin sampling as soon as the previous result arrives. When the run bit is cleared, the block drops to idle and throws away any conversion in flight. When the run bit is set again, the scan restarts at the first channel of the group. The converter is reached through a simple handshake: a start pulse carrying the channel number, then a done pulse that comes with the result.

Top module: `adc_scan_seq`

## Requirements
- R1: After synchronous reset the block is idle. `cnv_start`, `samp_o`, `eoc_flag` and `irq` are 0, and every result register reads 0.
- R2: A write on `ctl_we` takes `ctl_wdata` with this layout: bit 0 run, bit 1 interrupt enable, bits 3:2 group number, bits 5:4 channel count minus one, bit 7 flag write value. Group and count are latched when run goes from 0 to 1.
- R3: Within a scan, channels are converted in ascending order. `cnv_ch` = {group, index}, with the index running from 0 up to the count minus one.
- R4: When `cnv_done` arrives in the conversion phase, its 10-bit result is stored as {result, 6'b0} in the register addressed by `cnv_ch`. `rd_data` shows the register selected by `rd_sel`, with no latency.
- R5: After the last channel of the group is stored, `eoc_flag` is 1 from the next cycle on. The run bit is left set, and the next conversion uses the group's first channel.
- R6: `irq` is 1 exactly when `eoc_flag` is 1 and interrupt enable is 1.
- R7: `eoc_flag` is cleared only by a control write with bit 7 = 0 that follows a `stat_rd` strobe given while the flag was 1. Such a write with no earlier read leaves the flag set.
- R8: A write with run = 0 returns the block to idle. No further `cnv_start` pulses follow, and a conversion in flight is abandoned without updating its register.
- R9: Setting run again after a stop restarts at index 0 of the group.
- R10: The first `cnv_start` after a start comes d + SAMP_CYC cycles after the write, where d is between 1 and DIV. A later `cnv_start` comes exactly SAMP_CYC cycles after the previous `cnv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| stat_rd | input | 1 | Strobe marking a software read of the flag |
| rd_sel | input | 4 | Result register select |
| rd_data | output | 16 | Selected left-justified result |
| eoc_flag | output | 1 | Sticky end-of-scan flag |
| irq | output | 1 | Interrupt request |
| samp_o | output | 1 | High during the sampling phase |
| cnv_start | output | 1 | One-cycle converter start pulse |
| cnv_ch | output | 4 | Channel being converted |
| cnv_done | input | 1 | Converter result valid |
| cnv_result | input | 10 | Converter result |

## Verification
The bench measures the latency from start to the first converter start and compares it with the gap between later conversions. A design that applied the start delay to every channel, or skipped it on the first, would give the wrong counts. It also checks that the channel after the last one wraps back to index 0. It aborts a scan in mid-conversion, lets the stale done pulse arrive, and then checks that the old register value survived and that the restart begins at index 0 rather than at the channel where the scan stopped. It tries a flag clear with no preceding read and checks that the flag stays set. Finally it runs a group with interrupt enable off and checks that the request stays low.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int RES_W  = 10;
    localparam int DATA_W = 16;
    localparam int GRP_W  = 2;
    localparam int IDX_W  = 2;
    localparam int CH_W   = GRP_W + IDX_W;
    localparam int NCH    = 1 << CH_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SAMPLE,
        ST_CONV
    } seq_state_e;

    typedef struct packed {
        logic             flag_wr;
        logic             rsvd;
        logic [IDX_W-1:0] cnt_m1;
        logic [GRP_W-1:0] grp;
        logic             ie;
        logic             run;
    } ctl_byte_t;

    function automatic logic [DATA_W-1:0] left_justify(input logic [RES_W-1:0] r);
        return {r, {(DATA_W-RES_W){1'b0}}};
    endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_scan_pkg::*;
#(
    parameter int N  = NCH,
    parameter int AW = CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                regs_q[i] <= wdata;
            end
        end
    end

    assign rdata = regs_q[raddr];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int SAMP_CYC = 4,
    parameter int DIV      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              stat_rd,
    input  logic [CH_W-1:0]   rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              eoc_flag,
    output logic              irq,
    output logic              samp_o,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_ch,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_result
);
    localparam int SW = (SAMP_CYC > 2) ? $clog2(SAMP_CYC) : 1;
    localparam logic [SW-1:0] SAMP_LAST = SW'(SAMP_CYC - 1);

    ctl_byte_t        ctl;
    seq_state_e       state_q;
    logic             run_q, ie_q, flag_q, armed_q;
    logic [GRP_W-1:0] grp_q;
    logic [IDX_W-1:0] cnt_q, idx_q;
    logic [SW-1:0]    scnt_q;
    logic             tick, start_ev, stop_ev, store, grp_end, flag_clr;

    assign ctl      = ctl_byte_t'(ctl_wdata);
    assign start_ev = ctl_we && ctl.run && !run_q;
    assign stop_ev  = ctl_we && !ctl.run;
    assign store    = (state_q == ST_CONV) && cnv_done && !stop_ev;
    assign grp_end  = store && (idx_q == cnt_q);
    assign flag_clr = ctl_we && !ctl.flag_wr && armed_q;

    adc_clk_div #(.DIV(DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    adc_result_bank #(.N(NCH), .AW(CH_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (store),
        .waddr(cnv_ch),
        .wdata(left_justify(cnv_result)),
        .raddr(rd_sel),
        .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
            grp_q <= '0;
            cnt_q <= '0;
        end else if (ctl_we) begin
            run_q <= ctl.run;
            ie_q  <= ctl.ie;
            if (start_ev) begin
                grp_q <= ctl.grp;
                cnt_q <= ctl.cnt_m1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            scnt_q  <= '0;
        end else if (stop_ev) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else if (start_ev) begin
            state_q <= ST_DELAY;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_DELAY: if (tick) begin
                    state_q <= ST_SAMPLE;
                    scnt_q  <= '0;
                end
                ST_SAMPLE: begin
                    if (scnt_q == SAMP_LAST) state_q <= ST_CONV;
                    else                     scnt_q  <= scnt_q + 1'b1;
                end
                ST_CONV: if (cnv_done) begin
                    state_q <= ST_SAMPLE;
                    scnt_q  <= '0;
                    idx_q   <= (idx_q == cnt_q) ? '0 : idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (grp_end)       flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (flag_clr)                armed_q <= 1'b0;
            else if (stat_rd && flag_q)  armed_q <= 1'b1;
        end
    end

    assign eoc_flag  = flag_q;
    assign irq       = flag_q && ie_q;
    assign samp_o    = (state_q == ST_SAMPLE);
    assign cnv_start = samp_o && (scnt_q == SAMP_LAST);
    assign cnv_ch    = {grp_q, idx_q};
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_scan_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input seq_state_e       state,
    input logic             cnv_start,
    input logic             samp_o,
    input logic [IDX_W-1:0] idx,
    input logic [IDX_W-1:0] cnt,
    input logic             eoc_flag,
    input logic             ctl_we,
    input logic             irq,
    input logic             ie
);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!cnv_start && !samp_o));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (eoc_flag && !ctl_we) |=> eoc_flag);

    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (idx <= cnt));

    p_single_start_r10: assert property (@(posedge clk) disable iff (rst)
        cnv_start |=> !cnv_start);

    p_irq_enable_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie);

    p_delay_first_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY) |-> (idx == '0));
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (state_q),
    .cnv_start(cnv_start),
    .samp_o   (samp_o),
    .idx      (idx_q),
    .cnt      (cnt_q),
    .eoc_flag (eoc_flag),
    .ctl_we   (ctl_we),
    .irq      (irq),
    .ie       (ie_q)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int CLK_P = 10;
    localparam int SAMP  = 4;
    localparam int DIVN  = 4;
    localparam int LAT   = 3;
    localparam logic [3:0] VEC [4] = '{4'b0000, 4'b0111, 4'b1001, 4'b1110};

    logic        clk = 0, rst = 1, ctl_we = 0, stat_rd = 0, cnv_done = 0;
    logic [7:0]  ctl_wdata = 0;
    logic [3:0]  rd_sel = 0, cnv_ch, ch_hold = 0;
    logic [15:0] rd_data;
    logic        eoc_flag, irq, samp_o, cnv_start;
    logic [9:0]  cnv_result = 0;
    int          checks = 0, fails = 0, lat_cnt = 0, tok = 5, start_cnt = 0;
    logic [15:0] exp_reg [16];
    bit          finished = 0;

    adc_scan_seq #(.SAMP_CYC(SAMP), .DIV(DIVN)) uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .stat_rd(stat_rd), .rd_sel(rd_sel), .rd_data(rd_data),
        .eoc_flag(eoc_flag), .irq(irq), .samp_o(samp_o),
        .cnv_start(cnv_start), .cnv_ch(cnv_ch), .cnv_done(cnv_done),
        .cnv_result(cnv_result)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [9:0] res_of(input logic [3:0] ch, input int t);
        return 10'((int'(ch) * 37 + t) & 1023);
    endfunction

    function automatic logic [7:0] mk(input bit run, input bit ie,
                                      input logic [1:0] g, input logic [1:0] c, input bit fw);
        return {fw, 1'b0, c, g, ie, run};
    endfunction

    // converter model
    always @(posedge clk) begin
        if (rst) begin
            lat_cnt  <= 0;
            cnv_done <= 0;
        end else begin
            cnv_done <= 0;
            if (cnv_start) begin
                lat_cnt <= LAT;
                ch_hold <= cnv_ch;
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    cnv_done   <= 1;
                    cnv_result <= res_of(ch_hold, tok);
                end
            end
        end
    end

    always @(negedge clk) if (!rst && cnv_start) start_cnt++;

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] d);
        @(negedge clk);
        ctl_we = 1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic wait_start(output int n, output logic [3:0] ch);
        n = 0;
        ch = 0;
        for (int i = 0; i < 200; i++) begin
            n++;
            if (cnv_start) begin
                ch = cnv_ch;
                return;
            end
            @(negedge clk);
        end
        check("R10 start timeout", 0, n, 0);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (cnv_done) return;
        end
        check("R4 done timeout", 0, 0, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        check("watchdog", 0, 0, 1);
        summary();
    end

    initial begin
        int n, sc;
        logic [3:0] ch;
        logic [1:0] g, c;
        for (int i = 0; i < 16; i++) exp_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 cnv_start", cnv_start == 0, cnv_start, 0);
        check("R1 flag", eoc_flag == 0 && irq == 0, eoc_flag, 0);
        for (int i = 0; i < 16; i++) begin
            rd_sel = 4'(i);
            #1;
            check("R1 reg", rd_data == 0, rd_data, 0);
        end

        // vector walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < 4; i++) begin
            g = VEC[i][3:2];
            c = VEC[i][1:0];
            ctl_write(mk(1, 1, g, c, 1));
            wait_start(n, ch);
            check("R10 first delay", n >= SAMP + 1 && n <= SAMP + DIVN, n, SAMP + 1);
            for (int pass = 0; pass < 2; pass++) begin
                for (int k = 0; k <= int'(c); k++) begin
                    check("R3 channel order", ch == {g, 2'(k)}, ch, {g, 2'(k)});
                    rd_sel = {g, 2'(k)};
                    wait_done();
                    @(negedge clk);
                    exp_reg[{g, 2'(k)}] = {res_of({g, 2'(k)}, tok), 6'b0};
                    check("R4 stored left-justified", rd_data == exp_reg[{g, 2'(k)}],
                          rd_data, exp_reg[{g, 2'(k)}]);
                    if (k == int'(c)) begin
                        check("R5 flag at group end", eoc_flag == 1, eoc_flag, 1);
                        check("R6 irq with enable", irq == 1, irq, 1);
                    end
                    wait_start(n, ch);
                    check("R10 no delay later", n == SAMP, n, SAMP);
                end
            end
            check("R5 wraps to first", ch == {g, 2'b00}, ch, {g, 2'b00});
            ctl_write(mk(0, 1, g, c, 1));
            if (i == 0) begin
                sc = start_cnt;
                repeat (20) @(negedge clk);
                check("R8 no starts after stop", start_cnt == sc, start_cnt, sc);
                ctl_write(mk(0, 1, g, c, 0));
                check("R7 clear without read ignored", eoc_flag == 1, eoc_flag, 1);
            end
            @(negedge clk);
            stat_rd = 1;
            @(negedge clk);
            stat_rd = 0;
            ctl_write(mk(0, 1, g, c, 0));
            check("R7 clear after read", eoc_flag == 0 && irq == 0, eoc_flag, 0);
            repeat (10) @(negedge clk);
        end

        // R6 interrupt disabled
        ctl_write(mk(1, 0, 2'd0, 2'd0, 1));
        wait_start(n, ch);
        wait_done();
        @(negedge clk);
        check("R6 flag set ie off", eoc_flag == 1, eoc_flag, 1);
        check("R6 irq low ie off", irq == 0, irq, 0);
        ctl_write(mk(0, 0, 2'd0, 2'd0, 1));
        @(negedge clk);
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        ctl_write(mk(0, 0, 2'd0, 2'd0, 0));
        repeat (10) @(negedge clk);

        // R8 abort mid-conversion, R9 restart from first
        ctl_write(mk(1, 1, 2'd1, 2'd3, 1));
        wait_start(n, ch);
        wait_done();
        @(negedge clk);
        wait_start(n, ch);
        check("R3 second channel", ch == 4'd5, ch, 5);
        tok = 200;
        ctl_write(mk(0, 1, 2'd1, 2'd3, 1));
        repeat (12) @(negedge clk);
        rd_sel = 4'd5;
        #1;
        check("R8 abandoned result not stored", rd_data == exp_reg[5], rd_data, exp_reg[5]);
        ctl_write(mk(1, 1, 2'd1, 2'd3, 1));
        wait_start(n, ch);
        check("R9 restart at first channel", ch == 4'd4, ch, 4);
        check("R10 restart delay", n >= SAMP + 1 && n <= SAMP + DIVN, n, SAMP + 1);
        ctl_write(mk(0, 1, 2'd1, 2'd3, 1));
        repeat (10) @(negedge clk);
        summary();
    end
endmodule